// File: doc/BRIEF.md
# Transcoder Channel Cycle Sequencer

This block schedules the per-channel work of a multi-channel voice transcoder in the master clock domain. Each frame begins with a one-cycle frame-start pulse. The channels are then serviced one at a time, in ascending order. Each channel gets a busy window whose length is set only by its mode:

- decode: 123 cycles
- encode: 123 cycles
- initialize: 45 cycles
- disabled: 4 cycles

The signal-processing datapath is outside this block. The datapath sees the window through `busy_o`, the channel index, the mode and a running cycle index. A done pulse marks the final cycle of each window.

Holding the reset pin low keeps the sequencer in a quiet low-power state. When the pin goes high, a sweep runs one initialize window on every channel, back to back. Only after that sweep does the block accept frames. The sequencer has three further duties:

- A frame start that arrives while a frame is still unfinished abandons the rest of that frame and reports an overrun.
- A combinational budget output tells whether the configured modes fit in the frame length.
- Mode settings are sampled once per frame, so they may be rewritten freely while a frame runs.

Top module: `tcs_chan_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `done_o`, `ready_o` and `overrun_o` are all 0.
- R2: After `rst_n` rises, the first busy cycle is the third clock cycle. The sweep then runs one initialize window (45 cycles, mode code 11) per channel, channels 0 up to NUM_CH-1, with no gaps. `ready_o` is 0 during the sweep. `ready_o` becomes 1 in the cycle after the last sweep window and stays 1 until reset.
- R3: `frame_start_i` has no effect while `ready_o` is 0: it neither alters the sweep nor raises `overrun_o`.
- R4: A frame-start pulse while ready and idle makes the next cycle busy for channel 0 with `slot_cnt_o` equal to 0.
- R5: Channel i's mode is bits [2i+1:2i] of `chan_mode_i`. The codes are 00 disabled (4 cycles), 01 decode (123), 10 encode (123) and 11 initialize (45). A window stays busy for exactly that many cycles, with `slot_cnt_o` counting 0 up to length-1.
- R6: Windows follow in ascending channel order with no idle cycle between them. After the last channel, `busy_o` is 0 until the next frame start.
- R7: `done_o` is high only on the final cycle of each window, once per window, with `done_chan_o` equal to that channel.
- R8: Modes are sampled in the frame-start cycle. Changes to `chan_mode_i` during the frame do not affect its windows.
- R9: Suppose a frame start arrives while a frame is running and it is not the final cycle of the last window. Then `overrun_o` pulses for one cycle in the next cycle, the remaining windows are dropped, and a new frame starts from channel 0 with freshly sampled modes.
- R10: A frame start in the final cycle of the last window chains a new frame in the next cycle, without an overrun.
- R11: `budget_ok_o` is 1 exactly when the sum of the window lengths selected by `chan_mode_i` is at most FRAME_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset and power-down hold; its release starts the init sweep |
| frame_start_i | input | 1 | One-cycle frame start pulse |
| chan_mode_i | input | 2*NUM_CH | Per-channel mode codes |
| busy_o | output | 1 | Datapath enable, high during a window |
| busy_chan_o | output | CH_W | Channel being served |
| busy_mode_o | output | 2 | Mode code of the current window |
| slot_cnt_o | output | LIM_W | Cycle index within the window |
| done_o | output | 1 | Final cycle of a window |
| done_chan_o | output | CH_W | Channel whose window ends |
| ready_o | output | 1 | Init sweep complete, frames accepted |
| overrun_o | output | 1 | Frame abandoned by an early frame start |
| budget_ok_o | output | 1 | Configured modes fit in FRAME_CYCLES |

## Verification
The bench builds the block with NUM_CH=4 and FRAME_CYCLES=254, keeping the default window lengths. The sweep and the frames are therefore short, which leaves room for many random frames, chained frames, overruns and resets in mid-frame. With this frame length, the budget boundary falls exactly on two decode channels plus two disabled channels (254 cycles). Adding one initialize channel pushes the total past the limit, so both sides of the comparison are exercised.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_DEC  = 2'b01,
    MODE_ENC  = 2'b10,
    MODE_INIT = 2'b11
  } tcs_mode_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_SWEEP = 2'b01,
    ST_IDLE  = 2'b10,
    ST_FRAME = 2'b11
  } tcs_state_e;

  // Window length for a mode, given the configured lengths.
  function automatic int tcs_cost(tcs_mode_e m, int dec, int enc, int ini, int dis);
    case (m)
      MODE_DEC:  return dec;
      MODE_ENC:  return enc;
      MODE_INIT: return ini;
      default:   return dis;
    endcase
  endfunction

  function automatic int tcs_max4(int a, int b, int c, int d);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    if (d > r) r = d;
    return r;
  endfunction

endpackage

// File: rtl/tcs_rst_sync.sv
module tcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/tcs_slot_timer.sv
module tcs_slot_timer #(
  parameter int LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [LIM_W-1:0] count_o,
  output logic             last_o
);
  logic [LIM_W-1:0] count_q, count_d;
  logic             count_en;

  assign last_o   = run_i && (count_q == limit_i - 1'b1);
  assign count_en = run_i | restart_i;

  always_comb begin
    count_d = count_q;
    if (restart_i)  count_d = '0;
    else if (run_i) count_d = last_o ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

  // The cycle index never reaches the window length chosen by the scheduler.
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (count_q < limit_i));
endmodule

// File: rtl/tcs_budget.sv
module tcs_budget import tcs_pkg::*; #(
  parameter int NUM_CH       = 8,
  parameter int CYC_DEC      = 123,
  parameter int CYC_ENC      = 123,
  parameter int CYC_INIT     = 45,
  parameter int CYC_DIS      = 4,
  parameter int FRAME_CYCLES = 1000
) (
  input  logic [2*NUM_CH-1:0] modes_i,
  output logic                ok_o
);
  int cost [NUM_CH];
  int total;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cost
    assign cost[g] = tcs_cost(tcs_mode_e'(modes_i[2*g +: 2]),
                              CYC_DEC, CYC_ENC, CYC_INIT, CYC_DIS);
  end

  always_comb begin
    total = 0;
    for (int i = 0; i < NUM_CH; i++) total = total + cost[i];
  end

  assign ok_o = (total <= FRAME_CYCLES);
endmodule

// File: rtl/tcs_chan_sched.sv
module tcs_chan_sched import tcs_pkg::*; #(
  parameter int NUM_CH   = 8,
  parameter int CYC_DEC  = 123,
  parameter int CYC_ENC  = 123,
  parameter int CYC_INIT = 45,
  parameter int CYC_DIS  = 4,
  parameter int CH_W     = 3,
  parameter int LIM_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic [2*NUM_CH-1:0] modes_i,
  input  logic [LIM_W-1:0]    slot_cnt_i,
  input  logic                slot_last_i,
  output logic                run_o,
  output logic                restart_o,
  output logic [LIM_W-1:0]    limit_o,
  output logic [CH_W-1:0]     chan_o,
  output logic [1:0]          mode_o,
  output logic                ready_o,
  output logic                overrun_o
);
  tcs_state_e          state_q, state_d;
  logic [CH_W-1:0]     chan_q, chan_d;
  logic [2*NUM_CH-1:0] modes_q;
  logic                modes_ld;
  logic                ovr_q, ovr_d;
  logic                last_chan;
  tcs_mode_e           cur_mode;

  assign last_chan = (chan_q == CH_W'(NUM_CH - 1));
  assign run_o     = (state_q == ST_SWEEP) || (state_q == ST_FRAME);
  assign ready_o   = (state_q == ST_IDLE)  || (state_q == ST_FRAME);
  assign cur_mode  = (state_q == ST_SWEEP) ? MODE_INIT
                                           : tcs_mode_e'(modes_q[2*int'(chan_q) +: 2]);
  assign limit_o   = LIM_W'(tcs_cost(cur_mode, CYC_DEC, CYC_ENC, CYC_INIT, CYC_DIS));
  assign mode_o    = run_o ? cur_mode : MODE_OFF;
  assign chan_o    = chan_q;
  assign overrun_o = ovr_q;

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    modes_ld  = 1'b0;
    ovr_d     = 1'b0;
    restart_o = 1'b0;
    case (state_q)
      ST_OFF: begin
        state_d = ST_SWEEP;
        chan_d  = '0;
      end
      ST_SWEEP: begin
        if (slot_last_i) begin
          if (last_chan) begin
            state_d = ST_IDLE;
            chan_d  = '0;
          end else begin
            chan_d = chan_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (frame_start_i) begin
          state_d  = ST_FRAME;
          chan_d   = '0;
          modes_ld = 1'b1;
        end
      end
      default: begin
        if (frame_start_i && !(slot_last_i && last_chan)) begin
          ovr_d     = 1'b1;
          restart_o = 1'b1;
          chan_d    = '0;
          modes_ld  = 1'b1;
        end else if (slot_last_i) begin
          if (last_chan) begin
            chan_d = '0;
            if (frame_start_i) modes_ld = 1'b1;
            else               state_d  = ST_IDLE;
          end else begin
            chan_d = chan_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      chan_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        modes_q <= '0;
    else if (modes_ld) modes_q <= modes_i;
  end

  // Windows advance to the next channel index when one ends mid-frame.
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && slot_last_i && !last_chan && !restart_o) |=> (chan_q == $past(chan_q) + 1'b1));

  // An overrun always coincides with a fresh window on channel 0.
  assert_overrun_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> (state_q == ST_FRAME && chan_q == '0 && slot_cnt_i == '0));

  // Once ready, the block stays ready until reset.
  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // Frame starts before ready never produce an overrun.
  assert_no_start_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && frame_start_i) |=> !overrun_o);
endmodule

// File: rtl/tcs_chan_sequencer.sv
module tcs_chan_sequencer import tcs_pkg::*; #(
  parameter int NUM_CH       = 8,
  parameter int CYC_DEC      = 123,
  parameter int CYC_ENC      = 123,
  parameter int CYC_INIT     = 45,
  parameter int CYC_DIS      = 4,
  parameter int FRAME_CYCLES = 1000,
  localparam int MAX_CYC     = tcs_max4(CYC_DEC, CYC_ENC, CYC_INIT, CYC_DIS),
  localparam int LIM_W       = $clog2(MAX_CYC + 1),
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic [2*NUM_CH-1:0] chan_mode_i,
  output logic                busy_o,
  output logic [CH_W-1:0]     busy_chan_o,
  output logic [1:0]          busy_mode_o,
  output logic [LIM_W-1:0]    slot_cnt_o,
  output logic                done_o,
  output logic [CH_W-1:0]     done_chan_o,
  output logic                ready_o,
  output logic                overrun_o,
  output logic                budget_ok_o
);
  logic             srst_n;
  logic             run, restart, last;
  logic [LIM_W-1:0] limit, count;
  logic [CH_W-1:0]  chan;

  tcs_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n_o (srst_n)
  );

  tcs_chan_sched #(
    .NUM_CH(NUM_CH), .CYC_DEC(CYC_DEC), .CYC_ENC(CYC_ENC),
    .CYC_INIT(CYC_INIT), .CYC_DIS(CYC_DIS), .CH_W(CH_W), .LIM_W(LIM_W)
  ) u_sched (
    .clk           (clk),
    .rst_n         (srst_n),
    .frame_start_i (frame_start_i),
    .modes_i       (chan_mode_i),
    .slot_cnt_i    (count),
    .slot_last_i   (last),
    .run_o         (run),
    .restart_o     (restart),
    .limit_o       (limit),
    .chan_o        (chan),
    .mode_o        (busy_mode_o),
    .ready_o       (ready_o),
    .overrun_o     (overrun_o)
  );

  tcs_slot_timer #(.LIM_W(LIM_W)) u_timer (
    .clk       (clk),
    .rst_n     (srst_n),
    .run_i     (run),
    .restart_i (restart),
    .limit_i   (limit),
    .count_o   (count),
    .last_o    (last)
  );

  tcs_budget #(
    .NUM_CH(NUM_CH), .CYC_DEC(CYC_DEC), .CYC_ENC(CYC_ENC),
    .CYC_INIT(CYC_INIT), .CYC_DIS(CYC_DIS), .FRAME_CYCLES(FRAME_CYCLES)
  ) u_budget (
    .modes_i (chan_mode_i),
    .ok_o    (budget_ok_o)
  );

  assign busy_o      = run;
  assign busy_chan_o = chan;
  assign slot_cnt_o  = count;
  assign done_o      = last;
  assign done_chan_o = chan;

  // Reset pin low holds everything quiet.
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !done_o && !ready_o && !overrun_o));
endmodule

// File: tb/tb_tcs_chan_sequencer.sv
`timescale 1ns/1ps
module tb_tcs_chan_sequencer;
  localparam int N     = 4;
  localparam int FRAME = 254;
  localparam int CW    = $clog2(N);
  localparam int LW    = 7;

  logic          clk;
  logic          rst_n;
  logic          frame_start_i;
  logic [2*N-1:0] chan_mode_i;
  logic          busy_o, done_o, ready_o, overrun_o, budget_ok_o;
  logic [CW-1:0] busy_chan_o, done_chan_o;
  logic [1:0]    busy_mode_o;
  logic [LW-1:0] slot_cnt_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tcs_chan_sequencer #(.NUM_CH(N), .FRAME_CYCLES(FRAME)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .chan_mode_i(chan_mode_i),
    .busy_o(busy_o), .busy_chan_o(busy_chan_o), .busy_mode_o(busy_mode_o),
    .slot_cnt_o(slot_cnt_o), .done_o(done_o), .done_chan_o(done_chan_o),
    .ready_o(ready_o), .overrun_o(overrun_o), .budget_ok_o(budget_ok_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_cost(int m);
    case (m)
      1, 2:    return 123;
      3:       return 45;
      default: return 4;
    endcase
  endfunction

  function automatic int frame_len(logic [2*N-1:0] m);
    int s = 0;
    for (int i = 0; i < N; i++) s += exp_cost(int'(m[2*i +: 2]));
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checks consecutive cycles of a run starting at the current negedge.
  task automatic check_run(input logic [2*N-1:0] modes, input bit sweep, input int limit,
                           input bit exp_ovr, input bit scramble, input bit noise);
    int cyc = 0;
    int nbo = 0;
    for (int ch = 0; ch < N; ch++) begin
      int m   = sweep ? 3 : int'(modes[2*ch +: 2]);
      int len = exp_cost(m);
      int nb5 = 0, nb6 = 0, nb7 = 0, nb8 = 0;
      for (int k = 0; k < len; k++) begin
        bit fin;
        if (busy_o !== 1'b1 || int'(slot_cnt_o) != k || ready_o !== !sweep) nb5++;
        if (int'(busy_chan_o) != ch) nb6++;
        if (done_o !== (k == len - 1) || (done_o === 1'b1 && int'(done_chan_o) != ch)) nb7++;
        if (int'(busy_mode_o) != m) nb8++;
        if (overrun_o !== (cyc == 0 && exp_ovr)) nbo++;
        cyc++;
        fin = (cyc == limit) || (ch == N - 1 && k == len - 1);
        if (fin || k == len - 1) begin
          chk(nb5 == 0, "R5 window length and index", nb5, 0);
          chk(nb6 == 0, "R6 channel order", nb6, 0);
          chk(nb7 == 0, "R7 done pulse", nb7, 0);
          chk(nb8 == 0, sweep ? "R2 sweep mode" : "R8 sampled mode", nb8, 0);
        end
        if (fin) begin
          chk(nbo == 0, sweep ? "R3 start ignored in sweep" : "R9 overrun flag", nbo, 0);
          return;
        end
        if (scramble) chan_mode_i = 2*N'($urandom);
        if (noise) frame_start_i = 1'($urandom % 2);
        @(negedge clk);
      end
    end
  endtask

  task automatic start_frame(input logic [2*N-1:0] modes, input bit exp_ovr, input int limit,
                             input bit scramble, input string lbl);
    chan_mode_i   = modes;
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    chk(busy_o === 1'b1 && busy_chan_o == '0 && slot_cnt_o == '0 && overrun_o === exp_ovr,
        lbl, int'(busy_o), 1);
    check_run(modes, 1'b0, limit, exp_ovr, scramble, 1'b0);
  endtask

  task automatic expect_idle();
    frame_start_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && ready_o === 1'b1, "R6 idle after last channel",
        int'(busy_o), 0);
  endtask

  task automatic check_quiet(input string lbl);
    chk(busy_o === 1'b0 && done_o === 1'b0 && ready_o === 1'b0 && overrun_o === 1'b0,
        lbl, int'({busy_o, done_o, ready_o, overrun_o}), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_start_i = 1'b1;
    #1;
    check_quiet("R1 quiet in reset");
    repeat (3) begin
      @(negedge clk);
      check_quiet("R1 quiet in reset");
    end
    rst_n = 1'b1;
    frame_start_i = 1'b0;
    @(negedge clk);
    check_quiet("R2 release delay");
    @(negedge clk);
    check_quiet("R2 release delay");
    @(negedge clk);
    check_run('0, 1'b1, 0, 1'b0, 1'b1, 1'b1);
    frame_start_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0 && ready_o === 1'b1, "R2 ready after sweep", int'(ready_o), 1);
  endtask

  task automatic budget_case(input logic [2*N-1:0] m);
    bit exp;
    chan_mode_i = m;
    #1;
    exp = (frame_len(m) <= FRAME);
    chk(budget_ok_o === exp, "R11 budget", int'(budget_ok_o), int'(exp));
  endtask

  initial begin
    logic [2*N-1:0] m, m2;
    int total, k;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    frame_start_i = 1'b0;
    chan_mode_i = '0;
    do_reset();

    // R11 directed: boundary at 254 cycles, then random.
    budget_case(8'b00_00_00_00);
    budget_case(8'b10_10_10_10);
    budget_case(8'b00_00_01_01);
    budget_case(8'b00_11_01_01);
    for (int i = 0; i < 10; i++) budget_case(8'($urandom));
    @(negedge clk);

    // R4/R5 directed frames.
    start_frame(8'b00_00_00_00, 1'b0, 0, 1'b0, "R4 start latency");
    expect_idle();
    start_frame(8'b11_10_01_00, 1'b0, 0, 1'b0, "R4 start latency");
    expect_idle();

    // R8/R10 random frames, some chained in the final cycle.
    for (int i = 0; i < 20; i++) begin
      bit chain;
      m = 8'($urandom);
      start_frame(m, 1'b0, 0, 1'b1, "R4 start latency");
      chain = ($urandom % 3) == 0;
      while (chain) begin
        m2 = 8'($urandom);
        start_frame(m2, 1'b0, 0, 1'b1, "R10 chained start");
        chain = ($urandom % 4) == 0;
      end
      expect_idle();
      repeat ($urandom % 3) @(negedge clk);
    end

    // R9 overruns: earliest, latest and random points.
    for (int i = 0; i < 6; i++) begin
      m = 8'($urandom);
      total = frame_len(m);
      if (i == 0)      k = 1;
      else if (i == 1) k = total - 1;
      else             k = 1 + int'($urandom % 32'(total - 1));
      start_frame(m, 1'b0, k, 1'b0, "R4 start latency");
      m2 = 8'($urandom);
      start_frame(m2, 1'b1, 0, 1'b0, "R9 overrun restart");
      expect_idle();
    end

    // R1/R2 reset during a frame, then a normal frame.
    start_frame(8'b01_01_01_01, 1'b0, 10, 1'b0, "R4 start latency");
    do_reset();
    start_frame(8'b00_11_00_11, 1'b0, 0, 1'b0, "R4 start latency");
    expect_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule